// File: doc/BRIEF.md
# Half-Duplex Collision Jam and Back-Off Controller

This block reacts to collisions while a frame is being sent on a shared, half-duplex medium. It waits in an idle state until a collision is reported during transmission. It then takes a copy of the running check value and sends the bitwise inverse of that copy as a four-byte jam word. Because the jam word is the inverse of the check value, the partly sent frame can never pass the receiver's check.

After the last jam byte, the controller adds one to its count of collisions for the current frame and takes one of three paths:

- **Abort.** If the count is now above the programmed attempt limit, the controller reports an excessive-collision abort. The frame source then drops the frame.
- **Immediate retry.** If the skip bit is set, the controller asks at once for a retransmission from the first byte of the frame.
- **Back-off, then retry.** Otherwise the controller waits a random number of slot times, using truncated binary exponential back-off, and then asks for the retransmission.

A free-running linear feedback shift register supplies the random values. A successful frame clears the collision count.

Top module: `coll_backoff_ctrl`

## Requirements
- R1: A collision starts a jam only when half-duplex mode and transmit-active are both high and the controller is idle. In every other case the collision has no effect, and this includes collisions during a jam or during a back-off wait.
- R2: The jam word is the bitwise inverse of `crc_i` as sampled at the clock edge that detects the collision. `jam_valid_o` rises in the cycle that follows that edge.
- R3: Jam bytes go out least significant byte first (bits 7:0 of the jam word first, bits 31:24 last). Each clock edge with `byte_en_i` high moves to the next byte. `jam_valid_o` falls after the edge that takes the fourth byte.
- R4: A collision that is not skipped and not over the limit loads a wait count of `lfsr[k-1:0]`, where k is the smaller of n and 10 and n is the collision number for the frame, counting from 1. While waiting, `backoff_busy_o` is high and each edge with `slot_tick_i` high takes one from the count. The edge that finds the count at zero ends the wait and raises `retry_o`. With a tick on every cycle, the busy output therefore stays high for r+1 cycles.
- R5: The random source is a 16-bit register. It resets to 0xACE1 and on every clock edge out of reset takes the value {s[14:0], s[15]^s[13]^s[12]^s[10]}.
- R6: With `skip_backoff_i` high at the end of the jam, and the limit not exceeded, `retry_o` pulses in the cycle after the last jam byte and `backoff_busy_o` stays low.
- R7: When the collision number n is larger than `attempt_limit_i`, `excess_abort_o` pulses for one cycle in place of a retry. No back-off follows, and the collision count goes back to zero.
- R8: A high `frame_ok_i` while the controller is idle sets the collision count to zero, so the next collision is number 1.
- R9: While reset is high and after it, until the first collision, all outputs are zero.
- R10: `retry_o` and `excess_abort_o` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| half_duplex_i | input | 1 | Half-duplex mode is on |
| tx_active_i | input | 1 | A frame is being transmitted |
| collision_i | input | 1 | Collision reported by the line interface |
| crc_i | input | 32 | Running check value of the frame being sent |
| byte_en_i | input | 1 | Line takes one jam byte on this edge |
| slot_tick_i | input | 1 | One slot time has elapsed |
| skip_backoff_i | input | 1 | Retry at once without waiting |
| attempt_limit_i | input | 4 | Highest collision number that still gets a retry (nominally 15) |
| frame_ok_i | input | 1 | Current frame completed successfully |
| jam_data_o | output | 8 | Current jam byte |
| jam_valid_o | output | 1 | A jam byte is being presented |
| retry_o | output | 1 | Pulse: restart the frame from its first byte |
| excess_abort_o | output | 1 | Pulse: too many collisions, drop the frame |
| backoff_busy_o | output | 1 | Back-off wait in progress |

## Verification
The collision edge is followed one cycle later by `jam_valid_o` and byte 0. Each further byte is due one cycle after each `byte_en_i` edge. The abort or immediate-retry pulse appears one cycle after the fourth byte edge. On the back-off path, busy rises in that same cycle, and the retry pulse comes r+1 cycles after busy rises.

The bench changes inputs on falling edges and reads outputs on the next falling edge, so every result is read exactly one register stage after its cause. The expected wait r is taken from the bench's own model of the random register, using its value just before the jam-ending edge.

// File: rtl/cbk_pkg.sv
package cbk_pkg;

    localparam int          RND_W    = 16;
    localparam logic [15:0] RND_SEED = 16'hACE1;
    localparam int          BEB_CAP  = 10;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_JAM,
        ST_WAIT
    } cbk_state_e;

    typedef struct packed {
        logic retry;
        logic abort;
    } cbk_pulse_t;

    function automatic logic [RND_W-1:0] rnd_step(input logic [RND_W-1:0] s);
        return {s[RND_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    // Low min(n, BEB_CAP) bits set.
    function automatic logic [BEB_CAP-1:0] beb_mask(input int unsigned n);
        logic [BEB_CAP-1:0] m;
        for (int i = 0; i < BEB_CAP; i++) begin
            m[i] = (i < n);
        end
        return m;
    endfunction

endpackage

// File: rtl/cbk_rnd.sv
module cbk_rnd
    import cbk_pkg::*;
#(
    parameter int OUT_W = BEB_CAP
) (
    input  logic             clk,
    input  logic             rst,
    output logic [OUT_W-1:0] rnd_o
);
    logic [RND_W-1:0] s_q;

    always_ff @(posedge clk) begin
        if (rst) s_q <= RND_SEED;
        else     s_q <= rnd_step(s_q);
    end

    assign rnd_o = s_q[OUT_W-1:0];

    assert_rnd_alive_R5: assert property (@(posedge clk) disable iff (rst)
        s_q != '0);
endmodule

// File: rtl/cbk_jam.sv
module cbk_jam #(
    parameter int BYTES = 4,
    localparam int WORD_W = BYTES * 8,
    localparam int IDX_W  = (BYTES > 1) ? $clog2(BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [WORD_W-1:0] crc_i,
    input  logic              byte_en_i,
    output logic [7:0]        data_o,
    output logic              valid_o,
    output logic              done_o
);
    logic [WORD_W-1:0] word_q;
    logic [IDX_W-1:0]  idx_q;
    logic              last;

    assign last   = (idx_q == IDX_W'(BYTES - 1));
    assign done_o = valid_o && byte_en_i && last;
    assign data_o = word_q[idx_q*8 +: 8];

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q  <= '0;
            idx_q   <= '0;
            valid_o <= 1'b0;
        end else if (load_i) begin
            word_q  <= ~crc_i;
            idx_q   <= '0;
            valid_o <= 1'b1;
        end else if (valid_o && byte_en_i) begin
            idx_q <= last ? '0 : idx_q + IDX_W'(1);
            if (last) valid_o <= 1'b0;
        end
    end

    assert_jam_inverted_R2: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (valid_o && data_o == ~$past(crc_i[7:0])));

    assert_jam_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !byte_en_i) |=> (valid_o && $stable(data_o)));
endmodule

// File: rtl/cbk_backoff.sv
module cbk_backoff #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] count_i,
    input  logic         tick_i,
    output logic         busy_o,
    output logic         expire_o
);
    logic [W-1:0] cnt_q;

    assign expire_o = busy_o && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            busy_o <= 1'b0;
        end else if (load_i) begin
            cnt_q  <= count_i;
            busy_o <= 1'b1;
        end else if (expire_o) begin
            busy_o <= 1'b0;
        end else if (busy_o && tick_i) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assert_wait_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !tick_i && !expire_o) |=> (busy_o && cnt_q == $past(cnt_q)));

    assert_wait_load_R4: assert property (@(posedge clk) disable iff (rst)
        load_i |=> busy_o);
endmodule

// File: rtl/coll_backoff_ctrl.sv
module coll_backoff_ctrl
    import cbk_pkg::*;
#(
    parameter int JAM_BYTES = 4,
    parameter int LIM_W     = 4,
    localparam int CRC_W    = JAM_BYTES * 8,
    localparam int CNT_W    = LIM_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             half_duplex_i,
    input  logic             tx_active_i,
    input  logic             collision_i,
    input  logic [CRC_W-1:0] crc_i,
    input  logic             byte_en_i,
    input  logic             slot_tick_i,
    input  logic             skip_backoff_i,
    input  logic [LIM_W-1:0] attempt_limit_i,
    input  logic             frame_ok_i,
    output logic [7:0]       jam_data_o,
    output logic             jam_valid_o,
    output logic             retry_o,
    output logic             excess_abort_o,
    output logic             backoff_busy_o
);
    cbk_state_e         state_q;
    logic [CNT_W-1:0]   att_q;
    logic [CNT_W-1:0]   n_next;
    logic [BEB_CAP-1:0] rnd;
    logic [BEB_CAP-1:0] wait_val;
    cbk_pulse_t         pulse_q;
    logic               trigger, jam_done, over, wait_load, expire;

    assign trigger   = !rst && state_q == ST_IDLE && half_duplex_i
                       && tx_active_i && collision_i;
    assign n_next    = att_q + CNT_W'(1);
    assign over      = n_next > {1'b0, attempt_limit_i};
    assign wait_val  = rnd & beb_mask(int'(n_next));
    assign wait_load = jam_done && !over && !skip_backoff_i;

    cbk_rnd #(.OUT_W(BEB_CAP)) u_rnd (
        .clk   (clk),
        .rst   (rst),
        .rnd_o (rnd)
    );

    cbk_jam #(.BYTES(JAM_BYTES)) u_jam (
        .clk       (clk),
        .rst       (rst),
        .load_i    (trigger),
        .crc_i     (crc_i),
        .byte_en_i (byte_en_i),
        .data_o    (jam_data_o),
        .valid_o   (jam_valid_o),
        .done_o    (jam_done)
    );

    cbk_backoff #(.W(BEB_CAP)) u_wait (
        .clk      (clk),
        .rst      (rst),
        .load_i   (wait_load),
        .count_i  (wait_val),
        .tick_i   (slot_tick_i),
        .busy_o   (backoff_busy_o),
        .expire_o (expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            att_q   <= '0;
            pulse_q <= '0;
        end else begin
            pulse_q <= '0;
            unique case (state_q)
                ST_IDLE: begin
                    if (trigger)         state_q <= ST_JAM;
                    else if (frame_ok_i) att_q   <= '0;
                end
                ST_JAM: begin
                    if (jam_done) begin
                        if (over) begin
                            pulse_q.abort <= 1'b1;
                            att_q         <= '0;
                            state_q       <= ST_IDLE;
                        end else begin
                            att_q <= n_next;
                            if (skip_backoff_i) begin
                                pulse_q.retry <= 1'b1;
                                state_q       <= ST_IDLE;
                            end else begin
                                state_q <= ST_WAIT;
                            end
                        end
                    end
                end
                ST_WAIT: begin
                    if (expire) begin
                        pulse_q.retry <= 1'b1;
                        state_q       <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign retry_o        = pulse_q.retry;
    assign excess_abort_o = pulse_q.abort;

    assert_no_start_R1: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !half_duplex_i) |=> !jam_valid_o);

    assert_skip_path_R6: assert property (@(posedge clk) disable iff (rst)
        (jam_done && !over && skip_backoff_i) |=> (retry_o && !backoff_busy_o));

    assert_abort_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        excess_abort_o |-> (!backoff_busy_o && !jam_valid_o && att_q == '0));

    assert_pulse_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(retry_o && excess_abort_o));

    assert_pulse_single_R10: assert property (@(posedge clk) disable iff (rst)
        (retry_o || excess_abort_o) |=> !(retry_o || excess_abort_o));
endmodule

// File: tb/sim_coll_backoff_ctrl.sv
module sim_coll_backoff_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        half = 1'b0, txa = 1'b0, coll = 1'b0, ben = 1'b0;
    logic        tick = 1'b1, skip = 1'b0, fok = 1'b0;
    logic [31:0] crc = '0;
    logic [3:0]  limit = 4'd15;
    logic [7:0]  jam_data;
    logic        jam_valid, retry, abort_p, busy;

    int checks = 0, errors = 0, att_model = 0;
    bit done = 0;

    always #2 clk = ~clk;

    coll_backoff_ctrl u0 (
        .clk(clk), .rst(rst), .half_duplex_i(half), .tx_active_i(txa),
        .collision_i(coll), .crc_i(crc), .byte_en_i(ben), .slot_tick_i(tick),
        .skip_backoff_i(skip), .attempt_limit_i(limit), .frame_ok_i(fok),
        .jam_data_o(jam_data), .jam_valid_o(jam_valid), .retry_o(retry),
        .excess_abort_o(abort_p), .backoff_busy_o(busy)
    );

    // Independent model of the random source (R5)
    logic [15:0] m_rnd, m_prev;
    always @(posedge clk) begin
        if (rst) begin
            m_rnd  <= 16'hACE1;
            m_prev <= 16'hACE1;
        end else begin
            m_prev <= m_rnd;
            m_rnd  <= {m_rnd[14:0], m_rnd[15] ^ m_rnd[13] ^ m_rnd[12] ^ m_rnd[10]};
        end
    end

    function automatic int exp_wait(input logic [15:0] s, input int n);
        int k = (n > 10) ? 10 : n;
        return int'(s[9:0]) & ((1 << k) - 1);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic collide(input logic [31:0] c, input bit skp);
        int n, r, cnt;
        @(negedge clk);
        half = 1; txa = 1; coll = 1; crc = c; skip = skp;
        @(negedge clk);
        coll = 0; txa = 0; crc = $urandom;
        chk(jam_valid == 1'b1, "R2 jam_valid", 32'(jam_valid), 1);
        ben = 1;
        for (int b = 0; b < 4; b++) begin
            chk(jam_data == ~c[8*b +: 8], "R2/R3 jam byte", 32'(jam_data),
                32'(~c[8*b +: 8]));
            @(negedge clk);
        end
        ben = 0;
        chk(jam_valid == 1'b0, "R3 jam end", 32'(jam_valid), 0);
        n = att_model + 1;
        if (n > int'(limit)) begin
            att_model = 0;
            chk(abort_p == 1'b1 && retry == 1'b0 && busy == 1'b0, "R7 abort",
                {29'b0, abort_p, retry, busy}, 32'b100);
            @(negedge clk);
            chk(abort_p == 1'b0, "R10 abort single", 32'(abort_p), 0);
        end else begin
            att_model = n;
            if (skp) begin
                chk(retry == 1'b1 && busy == 1'b0 && abort_p == 1'b0, "R6 skip",
                    {29'b0, retry, busy, abort_p}, 32'b100);
            end else begin
                r = exp_wait(m_prev, n);
                cnt = 0;
                txa = 1; coll = 1;   // ignored while waiting (R1)
                while (busy && cnt < 2000) begin
                    cnt++;
                    @(negedge clk);
                end
                coll = 0; txa = 0;
                chk(cnt == r + 1, "R4/R5 wait length", 32'(cnt), 32'(r + 1));
                chk(retry == 1'b1 && abort_p == 1'b0 && jam_valid == 1'b0,
                    "R4/R10 retry after wait", {29'b0, retry, abort_p, jam_valid}, 32'b100);
            end
            @(negedge clk);
            chk(retry == 1'b0, "R10 retry single", 32'(retry), 0);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk({jam_valid, retry, abort_p, busy} == 4'b0, "R9 reset outputs",
            32'({jam_valid, retry, abort_p, busy}), 0);
        rst = 0;
        @(negedge clk);
        chk({jam_valid, retry, abort_p, busy, jam_data} == '0, "R9 after reset",
            32'({jam_valid, retry, abort_p, busy}), 0);

        // R1: full-duplex collision and collision without transmit
        half = 0; txa = 1; coll = 1;
        repeat (4) @(negedge clk);
        chk(jam_valid == 1'b0, "R1 full duplex", 32'(jam_valid), 0);
        half = 1; txa = 0;
        repeat (4) @(negedge clk);
        chk(jam_valid == 1'b0, "R1 no transmit", 32'(jam_valid), 0);
        coll = 0;

        // R7: default limit of 15, the 16th collision aborts
        limit = 4'd15;
        for (int i = 0; i < 16; i++) collide($urandom, 1'b0);

        // R8: successful frame clears the count
        collide(32'h1234_5678, 1'b0);
        collide(32'hFFFF_0000, 1'b0);
        @(negedge clk); fok = 1; @(negedge clk); fok = 0;
        att_model = 0;
        collide(32'h0000_0000, 1'b0);   // collision number 1: wait 0 or 1 (R8)
        @(negedge clk); fok = 1; @(negedge clk); fok = 0; att_model = 0;

        // R6: skip, then a small limit
        collide(32'hDEAD_BEEF, 1'b1);
        limit = 4'd1;
        collide(32'hA5A5_5A5A, 1'b1);   // number 2 > 1: abort (R7)
        limit = 4'd0;
        collide(32'h0F0F_F0F0, 1'b0);   // limit 0: first collision aborts (R7)

        // Constrained random mix
        for (int i = 0; i < 40; i++) begin
            limit = 4'($urandom_range(15, 2));
            if ($urandom_range(7, 0) == 0) begin
                @(negedge clk); fok = 1; @(negedge clk); fok = 0; att_model = 0;
            end
            collide($urandom, $urandom_range(3, 0) == 0);
        end

        done = 1;
        summary();
        $finish;
    end
endmodule